// File: doc/BRIEF.md
# Extended Mantissa Adder with Carry Renormalization

This block adds two extended-precision mantissas. Each operand is a 64-bit mantissa with an 8-bit guard byte under it, and the pair is treated as one 72-bit unsigned number. The add starts at the guard byte and ripples the carry up through the mantissa in 32-bit segments.

If the 72-bit sum carries out of the top, the result is renormalized:
- The exponent is incremented.
- The mantissa moves right by one place and its top bit is forced to 1.
- The guard byte shrinks to two meaningful bits: the bit shifted out of the mantissa and a sticky OR of the old guard.

If the incremented exponent reaches the all-ones code, the result becomes an overflow. The mantissa is cleared and an overflow flag is raised. An inexact flag is raised as well if the mantissa was nonzero before it was cleared.

The block sits after operand alignment and before rounding. An upstream stage presents aligned operands and the common exponent with a valid strobe. One clock later the result appears with its own valid strobe. The two status flags accumulate across operations until a clear input is pulsed.

Top module: `mant_carry_adder`

## Requirements
- R1: The result registers load on the clock edge where `in_valid` is high. `out_valid` is high in exactly the cycle after such an edge. While `in_valid` is low the result outputs hold their values. After reset every output is zero.
- R2: When the 72-bit sum `{a_mant,a_guard} + {b_mant,b_guard}` does not overflow 72 bits, `sum_mant` is the upper 64 bits of the sum and `sum_guard` is its low 8 bits. `exp_out` equals `exp_in`.
- R3: A carry out of the guard byte enters mantissa bit 0. A carry out of mantissa bit 31 enters bit 32. A carry out of bit 63 is the renormalize request.
- R4: On a renormalize request without overflow:
  - `sum_mant` is the 64-bit sum shifted right by one, with bit 63 set to 1.
  - `exp_out` is `exp_in + 1`.
- R5: On a renormalize request without overflow, `sum_guard` is built as follows:
  - Bit 7 is bit 0 of the unshifted 64-bit mantissa sum.
  - Bit 0 is the OR of all 8 bits of the unshifted guard sum.
  - Bits 6 to 1 are 0.
- R6: When a renormalize request occurs with `exp_in + 1` equal to 0x7FFF:
  - `exp_out` is 0x7FFF and `sum_mant` is 0.
  - `sum_guard` is the unshifted guard sum.
  - `ovf_flag` is set.
- R7: On an overflow (R6), `inx_flag` is set only if the unshifted 64-bit mantissa sum was nonzero.
- R8: `ovf_flag` and `inx_flag` are sticky: once set, they stay set until `flag_clr` is high at a clock edge, which clears them. If a new event and `flag_clr` coincide on the same edge, the flag ends set.
- R9: An operation with no renormalize request, or with a renormalize request that does not overflow, raises neither flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and exponent are valid this cycle |
| flag_clr | input | 1 | Clear both sticky flags |
| exp_in | input | 15 | Common exponent of both operands |
| a_mant | input | 64 | Operand A mantissa |
| a_guard | input | 8 | Operand A guard byte |
| b_mant | input | 64 | Operand B mantissa |
| b_guard | input | 8 | Operand B guard byte |
| out_valid | output | 1 | Result registers updated on the last edge |
| sum_mant | output | 64 | Result mantissa |
| sum_guard | output | 8 | Result guard byte |
| exp_out | output | 15 | Result exponent |
| ovf_flag | output | 1 | Sticky exponent-overflow flag |
| inx_flag | output | 1 | Sticky inexact flag |

## Verification
The operand patterns are chosen so that each one targets a single carry path:
- Small sums that stay below the guard boundary show plain pass-through.
- Guard bytes that sum past 0xFF show the guard-to-mantissa carry.
- A low word of all ones shows the carry across the 32-bit segment seam.
- Two mantissas with their top bits set show the renormalize shift.
- A pair whose guard sum is exactly zero separates the sticky bit from the shifted-out bit.

Overflow is driven at exponent 0x7FFE twice: once with a nonzero mantissa sum and once with a zero one, which tells the inexact rule apart from the overflow rule. The flag-clear timing is tested alone and coincident with a new event. A short run of pseudo-random operands is then compared against a model based on a 73-bit shift.

// File: rtl/mant_add_pkg.sv
package mant_add_pkg;

  // Classification of one addition result.
  typedef enum logic [1:0] {
    RK_PASS  = 2'd0,
    RK_SHIFT = 2'd1,
    RK_OVF   = 2'd2
  } res_kind_e;

endpackage

// File: rtl/mant_sum_core.sv
module mant_sum_core #(
  parameter int MANT_W  = 64,
  parameter int GUARD_W = 8,
  parameter int SEG_W   = 32
) (
  input  logic [MANT_W-1:0]  a_mant,
  input  logic [GUARD_W-1:0] a_guard,
  input  logic [MANT_W-1:0]  b_mant,
  input  logic [GUARD_W-1:0] b_guard,
  output logic [MANT_W-1:0]  s_mant,
  output logic [GUARD_W-1:0] s_guard,
  output logic               carry_out
);
  localparam int NSEG = MANT_W / SEG_W;

  // Adds one mantissa segment with carry-in and returns {carry, sum}.
  function automatic logic [SEG_W:0] seg_add(input logic [SEG_W-1:0] x,
                                             input logic [SEG_W-1:0] y,
                                             input logic ci);
    return (SEG_W+1)'(x) + (SEG_W+1)'(y) + (SEG_W+1)'(ci);
  endfunction

  logic [NSEG:0] seg_cy;

  // The guard byte is added first; its carry starts the mantissa ripple.
  assign {seg_cy[0], s_guard} = (GUARD_W+1)'(a_guard) + (GUARD_W+1)'(b_guard);

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    assign {seg_cy[g+1], s_mant[g*SEG_W +: SEG_W]} =
      seg_add(a_mant[g*SEG_W +: SEG_W], b_mant[g*SEG_W +: SEG_W], seg_cy[g]);
  end

  assign carry_out = seg_cy[NSEG];
endmodule

// File: rtl/mant_renorm.sv
module mant_renorm
  import mant_add_pkg::*;
#(
  parameter int MANT_W  = 64,
  parameter int GUARD_W = 8,
  parameter int EXP_W   = 15
) (
  input  logic [MANT_W-1:0]  s_mant,
  input  logic [GUARD_W-1:0] s_guard,
  input  logic               carry,
  input  logic [EXP_W-1:0]   exp_in,
  output logic [MANT_W-1:0]  r_mant,
  output logic [GUARD_W-1:0] r_guard,
  output logic [EXP_W-1:0]   r_exp,
  output logic               ovf_evt,
  output logic               inx_evt
);
  localparam logic [EXP_W-1:0] EXP_MAX = '1;

  // Moves the mantissa right by one, inserting the carry as the new MSB.
  function automatic logic [MANT_W-1:0] shift_in_one(input logic [MANT_W-1:0] m);
    return {1'b1, m[MANT_W-1:1]};
  endfunction

  // Collapses the guard byte: shifted-out bit on top, sticky OR at bit 0.
  function automatic logic [GUARD_W-1:0] fold_guard(input logic lsb,
                                                    input logic [GUARD_W-1:0] gd);
    logic [GUARD_W-1:0] r;
    r = '0;
    r[GUARD_W-1] = lsb;
    r[0] = |gd;
    return r;
  endfunction

  logic [EXP_W-1:0] exp_inc;
  res_kind_e        kind;

  assign exp_inc = exp_in + EXP_W'(1);

  always_comb begin
    if (!carry)                 kind = RK_PASS;
    else if (exp_inc == EXP_MAX) kind = RK_OVF;
    else                        kind = RK_SHIFT;
  end

  always_comb begin
    r_mant  = s_mant;
    r_guard = s_guard;
    r_exp   = exp_in;
    ovf_evt = 1'b0;
    inx_evt = 1'b0;
    unique case (kind)
      RK_SHIFT: begin
        r_mant  = shift_in_one(s_mant);
        r_guard = fold_guard(s_mant[0], s_guard);
        r_exp   = exp_inc;
      end
      RK_OVF: begin
        r_mant  = '0;
        r_exp   = EXP_MAX;
        ovf_evt = 1'b1;
        inx_evt = |s_mant;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sticky_flags.sv
module sticky_flags #(
  parameter int NFLAG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [NFLAG-1:0] set,
  output logic [NFLAG-1:0] flags
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)     flags[i] <= 1'b0;
      else if (set[i]) flags[i] <= 1'b1;
      else if (clr)    flags[i] <= 1'b0;
    end

    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flags[i] && !clr |=> flags[i]);

    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr && !set[i] |=> !flags[i]);
  end
endmodule

// File: rtl/mant_carry_adder.sv
module mant_carry_adder #(
  parameter int MANT_W  = 64,
  parameter int GUARD_W = 8,
  parameter int EXP_W   = 15,
  parameter int SEG_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               flag_clr,
  input  logic [EXP_W-1:0]   exp_in,
  input  logic [MANT_W-1:0]  a_mant,
  input  logic [GUARD_W-1:0] a_guard,
  input  logic [MANT_W-1:0]  b_mant,
  input  logic [GUARD_W-1:0] b_guard,
  output logic               out_valid,
  output logic [MANT_W-1:0]  sum_mant,
  output logic [GUARD_W-1:0] sum_guard,
  output logic [EXP_W-1:0]   exp_out,
  output logic               ovf_flag,
  output logic               inx_flag
);
  localparam logic [EXP_W-1:0] EXP_MAX = '1;

  // Named internal events, shared by datapath and assertions.
  logic [MANT_W-1:0]  raw_mant;
  logic [GUARD_W-1:0] raw_guard;
  logic               carry_w;
  logic [MANT_W-1:0]  nx_mant;
  logic [GUARD_W-1:0] nx_guard;
  logic [EXP_W-1:0]   nx_exp;
  logic               ovf_evt_w;
  logic               inx_evt_w;
  logic [1:0]         flag_set;
  logic [1:0]         flag_q;

  mant_sum_core #(.MANT_W(MANT_W), .GUARD_W(GUARD_W), .SEG_W(SEG_W)) u_sum (
    .a_mant(a_mant), .a_guard(a_guard), .b_mant(b_mant), .b_guard(b_guard),
    .s_mant(raw_mant), .s_guard(raw_guard), .carry_out(carry_w)
  );

  mant_renorm #(.MANT_W(MANT_W), .GUARD_W(GUARD_W), .EXP_W(EXP_W)) u_renorm (
    .s_mant(raw_mant), .s_guard(raw_guard), .carry(carry_w), .exp_in(exp_in),
    .r_mant(nx_mant), .r_guard(nx_guard), .r_exp(nx_exp),
    .ovf_evt(ovf_evt_w), .inx_evt(inx_evt_w)
  );

  assign flag_set = {in_valid & inx_evt_w, in_valid & ovf_evt_w};

  sticky_flags #(.NFLAG(2)) u_flags (
    .clk(clk), .rst_n(rst_n), .clr(flag_clr), .set(flag_set), .flags(flag_q)
  );

  assign ovf_flag = flag_q[0];
  assign inx_flag = flag_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      sum_mant  <= '0;
      sum_guard <= '0;
      exp_out   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        sum_mant  <= nx_mant;
        sum_guard <= nx_guard;
        exp_out   <= nx_exp;
      end
    end
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R1
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(sum_mant) && $stable(exp_out));
  // R2
  pass_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !carry_w |=> exp_out == $past(exp_in));
  // R4
  shift_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && carry_w && !ovf_evt_w |=>
      sum_mant[MANT_W-1] && exp_out == $past(exp_in) + EXP_W'(1));
  // R5
  guard_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && carry_w && !ovf_evt_w |=> sum_guard[GUARD_W-2:1] == '0);
  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ovf_evt_w |=> sum_mant == '0 && exp_out == EXP_MAX && ovf_flag);
  // R7
  inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ovf_evt_w && (raw_mant != '0) |=> inx_flag);
  // R7
  inexact_needs_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inx_flag) |-> ovf_flag);
  // R9
  quiet_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_flag && !(in_valid && ovf_evt_w) |=> !ovf_flag && !inx_flag);
endmodule

// File: tb/mant_carry_adder_test.sv
module mant_carry_adder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        flag_clr = 1'b0;
  logic [14:0] exp_in = '0;
  logic [63:0] a_mant = '0, b_mant = '0;
  logic [7:0]  a_guard = '0, b_guard = '0;
  logic        out_valid, ovf_flag, inx_flag;
  logic [63:0] sum_mant;
  logic [7:0]  sum_guard;
  logic [14:0] exp_out;

  int n_chk = 0;
  int n_bad = 0;
  logic m_ovf = 1'b0, m_inx = 1'b0;

  always #2 clk = ~clk;

  mant_carry_adder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .flag_clr(flag_clr),
    .exp_in(exp_in), .a_mant(a_mant), .a_guard(a_guard),
    .b_mant(b_mant), .b_guard(b_guard), .out_valid(out_valid),
    .sum_mant(sum_mant), .sum_guard(sum_guard), .exp_out(exp_out),
    .ovf_flag(ovf_flag), .inx_flag(inx_flag)
  );

  task automatic chk(input bit ok, input string req, input logic [87:0] act,
                     input logic [87:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Independent model: a 73-bit sum, shifted as one number when it carries.
  task automatic run_op(input string req, input logic [14:0] e,
                        input logic [63:0] am, input logic [7:0] ag,
                        input logic [63:0] bm, input logic [7:0] bg);
    logic [72:0] full;
    logic [63:0] xm;
    logic [7:0]  xg;
    logic [14:0] xe;
    logic        ov, ix;
    full = {1'b0, am, ag} + {1'b0, bm, bg};
    xm = full[71:8]; xg = full[7:0]; xe = e; ov = 1'b0; ix = 1'b0;
    if (full[72]) begin
      if (e + 15'd1 == 15'h7FFF) begin
        ov = 1'b1; ix = (full[71:8] != 0); xm = '0; xe = 15'h7FFF;
      end else begin
        xm = full[72:9];
        xg = {full[8], 6'b0, (full[7:0] != 0)};
        xe = e + 15'd1;
      end
    end
    m_ovf = m_ovf | ov;
    m_inx = m_inx | ix;
    @(negedge clk);
    exp_in = e; a_mant = am; a_guard = ag; b_mant = bm; b_guard = bg;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid, {req, " R1 valid"}, 88'(out_valid), 88'(1));
    chk(sum_mant == xm && sum_guard == xg, {req, " mant/guard"},
        {16'h0, sum_mant, sum_guard}, {16'h0, xm, xg});
    chk(exp_out == xe, {req, " exp"}, 88'(exp_out), 88'(xe));
    chk(ovf_flag == m_ovf && inx_flag == m_inx, {req, " flags"},
        88'({ovf_flag, inx_flag}), 88'({m_ovf, m_inx}));
  endtask

  task automatic clear_flags();
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    m_ovf = 1'b0; m_inx = 1'b0;
    chk(!ovf_flag && !inx_flag, "R8 clear", 88'({ovf_flag, inx_flag}), 88'(0));
  endtask

  task automatic t_reset();
    chk(!out_valid && sum_mant == 0 && sum_guard == 0 && exp_out == 0 &&
        !ovf_flag && !inx_flag, "R1 reset state",
        {out_valid, ovf_flag, inx_flag, sum_mant, sum_guard, exp_out}, 88'(0));
  endtask

  task automatic t_hold();
    logic [63:0] m;
    m = sum_mant;
    @(negedge clk);
    a_mant = 64'h1234; b_mant = 64'h9999;
    @(negedge clk);
    chk(!out_valid && sum_mant == m, "R1 hold", 88'(sum_mant), 88'(m));
  endtask

  task automatic t_coincident_clear();
    // R8: an overflow event on the same edge as a clear leaves the flag set
    @(negedge clk);
    flag_clr = 1'b1; exp_in = 15'h7FFE; in_valid = 1'b1;
    a_mant = 64'h8000_0000_0000_0000; b_mant = 64'h8000_0000_0000_0000;
    a_guard = 8'h00; b_guard = 8'h00;
    @(negedge clk);
    flag_clr = 1'b0; in_valid = 1'b0;
    chk(ovf_flag && !inx_flag, "R8 event beats clear",
        88'({ovf_flag, inx_flag}), 88'(2'b10));
    m_ovf = 1'b1; m_inx = 1'b0;
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        // R2 plain pass-through
        run_op("R2 no carry", 15'h3FFF, 64'h0000_0000_0000_0001, 8'h10,
               64'h0000_0000_0000_0002, 8'h20);
        // R3 guard carry into mantissa bit 0
        run_op("R3 guard carry", 15'h0100, 64'h0000_0000_0000_00FF, 8'hFF,
               64'h0, 8'h01);
        // R3 carry across the 32-bit seam
        run_op("R3 seam carry", 15'h0100, 64'h0000_0000_FFFF_FFFF, 8'hFF,
               64'h0, 8'h01);
        // R4 R5 renormalize with odd mantissa and nonzero guard
        run_op("R4 R5 shift", 15'h1234, 64'h8000_0000_0000_0001, 8'h03,
               64'h8000_0000_0000_0000, 8'h00);
        // R5 guard sums to zero: sticky bit stays 0
        run_op("R5 zero sticky", 15'h0040, 64'hFFFF_FFFF_FFFF_FFFF, 8'h80,
               64'h0, 8'h80);
        // R9 no flags raised so far
        chk(!ovf_flag && !inx_flag, "R9 quiet", 88'({ovf_flag, inx_flag}), 88'(0));
        // R6 R7 overflow with nonzero mantissa
        run_op("R6 R7 ovf inexact", 15'h7FFE, 64'h8000_0000_0000_0001, 8'h5A,
               64'h8000_0000_0000_0001, 8'h00);
        // R8 sticky through a quiet op
        run_op("R8 sticky", 15'h0002, 64'h1, 8'h0, 64'h1, 8'h0);
        t_hold();
        clear_flags();
        // R7 overflow with zero mantissa: no inexact
        run_op("R6 R7 ovf exact", 15'h7FFE, 64'h8000_0000_0000_0000, 8'h00,
               64'h8000_0000_0000_0000, 8'h00);
        clear_flags();
        t_coincident_clear();
        clear_flags();
        begin
          logic [63:0] lf;
          lf = 64'hACE1_0F0F_5A5A_1357;
          for (int i = 0; i < 24; i++) begin
            lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
            run_op("R2 R4 R5 sweep", 15'(14'(lf[20:6])), lf | 64'h8000_0000_0000_0000,
                   lf[7:0], {lf[31:0], lf[63:32]}, lf[15:8]);
          end
        end
      end
      begin
        repeat (20000) @(negedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule